// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block sits between a 32-bit register port and an I2C master bus engine. Software queues transfer commands into a command FIFO. Each command carries a data or address byte plus start and stop request bits. The engine pops the commands in order. Bytes the engine receives land in an RX FIFO, and software drains them by reading the RX data word. Both FIFOs have a parameterised depth, with a default of 4.

The block also holds the configuration the engine needs. This covers the core enable, the fast-speed select and three 16-bit timing counts: SCL low, SCL high and SDA hold. Five sticky status flags drive a single interrupt line through per-flag enables:
- transmit-room
- receive-data
- NACK
- arbitration loss
- receive overflow

The two ready flags follow programmable FIFO level thresholds. A ready flag that is cleared while its condition still holds comes back one cycle later.

Register word indexes (the byte offset is four times the index): 0 command push, 1 RX data, 2 control, 3 interrupt enable, 4 interrupt status, 5 core status, 6 command level, 7 RX level, 8 SCL low, 9 SCL high, 10 SDA hold. Read data is combinational on `regAddr`. A read strobe only matters for its side effect, which is an RX pop at word 1.

Top module: `i2c_reg_front`

## Requirements
- R1: After reset, the following are all zero: control, interrupt enable, status flags, both FIFO levels, the timing counts and `irq`. `engCmdValid` is low.
- R2: Control register (word 2) layout:
  - bit 0 enables the core;
  - bit 1 selects fast speed;
  - bits 3:2 hold the command threshold;
  - bits 5:4 hold the RX threshold.
  It reads back as written, and bits 0 and 1 drive `ctrlEnable` and `ctrlFast`.
- R3: Command FIFO push and pop:
  - A write to word 0 pushes `regWrData[9:0]`.
  - The engine sees the oldest entry on `engCmdData` with `engCmdValid` high, and removes it with `engCmdPop`.
  - A push while the FIFO holds DEPTH entries is ignored.
  - Word 6 returns the occupancy.
- R4: RX FIFO behaviour:
  - `engRxPush` stores `engRxData`.
  - Reading word 1 returns the oldest byte in bits 7:0 and removes it.
  - Reading word 1 while the FIFO is empty returns 0.
  - Word 7 returns the occupancy.
- R5: Status bit 0 (TX ready) sets on each clock edge at which the core is enabled and the command level is at or below the command threshold.
- R6: Status bit 1 (RX ready) sets on each clock edge at which the core is enabled and the RX level is above the RX threshold.
- R7: An engine push into a full RX FIFO drops the byte and sets status bit 4 (RX overflow).
- R8: A pulse on `engNack` sets status bit 2, and a pulse on `engArbLost` sets status bit 3.
- R9: Writing 1 to a bit of word 4 clears that status bit; bits written 0 keep their value. A clear takes precedence over a ready condition in the same cycle, so a ready bit whose condition still holds returns on the following edge.
- R10: `irq` is high exactly when some status bit is set together with its enable bit. Enables sit in word 3, bits 4:0, using the same bit order as the status flags.
- R11: Word 5 bit 0 reflects `engBusy`. Words 8, 9 and 10 hold the SCL low, SCL high and SDA hold counts (low 16 bits), which drive the matching outputs.
- R12: While the core is disabled:
  - both FIFOs are held empty;
  - command writes and engine pushes are dropped;
  - neither ready bit sets.
- R13: Reads of word 0 and of unmapped words return 0. Writes to read-only or unmapped words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops RX at word 1) |
| regAddr | input | 4 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| engCmdValid | output | 1 | Command FIFO not empty |
| engCmdData | output | 10 | Oldest command (9 start, 8 stop, 7:0 byte) |
| engCmdPop | input | 1 | Engine consumes the oldest command |
| engRxPush | input | 1 | Engine delivers a received byte |
| engRxData | input | 8 | Received byte |
| engNack | input | 1 | NACK detected pulse |
| engArbLost | input | 1 | Arbitration lost pulse |
| engBusy | input | 1 | Engine is active |
| ctrlEnable | output | 1 | Core enable |
| ctrlFast | output | 1 | Fast bus speed select |
| sclLowCnt | output | TIME_W | SCL low count |
| sclHighCnt | output | TIME_W | SCL high count |
| sdaHoldCnt | output | TIME_W | SDA hold count |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- The engine raises `engCmdPop` only while `engCmdValid` is high, or the pop is harmless.
- `engNack` and `engArbLost` are single-cycle pulses.
- Register strobes are never asserted together with reset.

The overflow property assumes no RX pop lands in the same cycle as a push into a full FIFO. The stimulus meets all of this: it drives every strobe for exactly one cycle from a falling edge, keeps register reads and engine pushes in separate cycles, and only pops commands after checking `engCmdValid`.

// File: rtl/i2c_front_pkg.sv
package i2c_front_pkg;

  localparam int ADDR_W = 4;
  localparam int CMD_W  = 10;
  localparam int BYTE_W = 8;
  localparam int NFLAG  = 5;

  localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] A_RXD    = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CORE   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMDLVL = 4'd6;
  localparam logic [ADDR_W-1:0] A_RXLVL  = 4'd7;
  localparam logic [ADDR_W-1:0] A_SCLLO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_SCLHI  = 4'd9;
  localparam logic [ADDR_W-1:0] A_HOLD   = 4'd10;

  localparam int F_TXRDY = 0;
  localparam int F_RXRDY = 1;
  localparam int F_NACK  = 2;
  localparam int F_ARB   = 3;
  localparam int F_RXOVF = 4;

  // control register image, enable in bit 0
  typedef struct packed {
    logic [1:0] rxThr;
    logic [1:0] cmdThr;
    logic       fast;
    logic       enable;
  } ctrl_t;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic cmdPush;
    logic rxPop;
    logic ctrlWr;
    logic ienWr;
    logic statClr;
    logic sclLoWr;
    logic sclHiWr;
    logic holdWr;
  } strobe_t;

endpackage

// File: rtl/i2c_front_fifo.sv
module i2c_front_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (level == LVL_W'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign rdata  = store[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= wdata;
  end

endmodule

// File: rtl/i2c_front_ctrl.sv
module i2c_front_ctrl
  import i2c_front_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  ctrl_t             ctrlReg,
  input  logic [LVL_W-1:0]  cmdLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              rxFull,
  input  logic              engRxPush,
  input  logic              engNack,
  input  logic              engArbLost,
  output strobe_t           strobes,
  output logic [NFLAG-1:0]  stat,
  output logic [NFLAG-1:0]  ien,
  output logic              irq
);

  logic [NFLAG-1:0] clrMask, lvlSet, evtSet;
  logic txCond, rxCond, ovfEvt;
  logic unusedWr;

  assign unusedWr = ^regWrData[31:NFLAG];

  always_comb begin
    strobes         = '0;
    strobes.cmdPush = regWrEn && (regAddr == A_CMD);
    strobes.rxPop   = regRdEn && (regAddr == A_RXD);
    strobes.ctrlWr  = regWrEn && (regAddr == A_CTRL);
    strobes.ienWr   = regWrEn && (regAddr == A_IEN);
    strobes.statClr = regWrEn && (regAddr == A_STAT);
    strobes.sclLoWr = regWrEn && (regAddr == A_SCLLO);
    strobes.sclHiWr = regWrEn && (regAddr == A_SCLHI);
    strobes.holdWr  = regWrEn && (regAddr == A_HOLD);
  end

  assign txCond = ctrlReg.enable && (cmdLevel <= LVL_W'(ctrlReg.cmdThr));
  assign rxCond = ctrlReg.enable && (rxLevel > LVL_W'(ctrlReg.rxThr));
  assign ovfEvt = engRxPush && ctrlReg.enable && rxFull;

  always_comb begin
    lvlSet          = '0;
    lvlSet[F_TXRDY] = txCond;
    lvlSet[F_RXRDY] = rxCond;
    evtSet          = '0;
    evtSet[F_NACK]  = engNack;
    evtSet[F_ARB]   = engArbLost;
    evtSet[F_RXOVF] = ovfEvt;
    clrMask         = strobes.statClr ? regWrData[NFLAG-1:0] : '0;
  end

  // level-driven bits lose to a clear, engine events win over it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      ien  <= '0;
    end else begin
      stat <= ((stat | lvlSet) & ~clrMask) | evtSet;
      if (strobes.ienWr) ien <= regWrData[NFLAG-1:0];
    end
  end

  assign irq = |(stat & ien);

endmodule

// File: rtl/i2c_front_dp.sv
module i2c_front_dp
  import i2c_front_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TIME_W = 16,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [NFLAG-1:0]  stat,
  input  logic [NFLAG-1:0]  ien,
  input  logic              engBusy,
  input  logic              engCmdPop,
  input  logic              engRxPush,
  input  logic [BYTE_W-1:0] engRxData,
  output ctrl_t             ctrlReg,
  output logic [31:0]       regRdData,
  output logic [LVL_W-1:0]  cmdLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              rxFull,
  output logic              engCmdValid,
  output logic [CMD_W-1:0]  engCmdData,
  output logic [TIME_W-1:0] sclLowCnt,
  output logic [TIME_W-1:0] sclHighCnt,
  output logic [TIME_W-1:0] sdaHoldCnt
);

  logic flush, cmdFull, cmdEmpty, rxEmpty;
  logic [CMD_W-1:0]  cmdHead;
  logic [BYTE_W-1:0] rxHead;
  logic unusedWr;

  assign unusedWr = ^regWrData;
  assign flush    = !ctrlReg.enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg    <= '0;
      sclLowCnt  <= '0;
      sclHighCnt <= '0;
      sdaHoldCnt <= '0;
    end else begin
      if (strobes.ctrlWr)  ctrlReg    <= ctrl_t'(regWrData[$bits(ctrl_t)-1:0]);
      if (strobes.sclLoWr) sclLowCnt  <= regWrData[TIME_W-1:0];
      if (strobes.sclHiWr) sclHighCnt <= regWrData[TIME_W-1:0];
      if (strobes.holdWr)  sdaHoldCnt <= regWrData[TIME_W-1:0];
    end
  end

  i2c_front_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) cmdFifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (strobes.cmdPush),
    .pop   (engCmdPop),
    .wdata (regWrData[CMD_W-1:0]),
    .rdata (cmdHead),
    .full  (cmdFull),
    .empty (cmdEmpty),
    .level (cmdLevel)
  );

  i2c_front_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) rxFifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (engRxPush),
    .pop   (strobes.rxPop),
    .wdata (engRxData),
    .rdata (rxHead),
    .full  (rxFull),
    .empty (rxEmpty),
    .level (rxLevel)
  );

  assign engCmdValid = !cmdEmpty;
  assign engCmdData  = cmdEmpty ? '0 : cmdHead;

  logic unusedFull;
  assign unusedFull = cmdFull;

  always_comb begin
    case (regAddr)
      A_RXD:    regRdData = rxEmpty ? '0 : 32'(rxHead);
      A_CTRL:   regRdData = 32'(ctrlReg);
      A_IEN:    regRdData = 32'(ien);
      A_STAT:   regRdData = 32'(stat);
      A_CORE:   regRdData = 32'(engBusy);
      A_CMDLVL: regRdData = 32'(cmdLevel);
      A_RXLVL:  regRdData = 32'(rxLevel);
      A_SCLLO:  regRdData = 32'(sclLowCnt);
      A_SCLHI:  regRdData = 32'(sclHighCnt);
      A_HOLD:   regRdData = 32'(sdaHoldCnt);
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/i2c_reg_front.sv
module i2c_reg_front
  import i2c_front_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TIME_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              engCmdValid,
  output logic [9:0]        engCmdData,
  input  logic              engCmdPop,
  input  logic              engRxPush,
  input  logic [7:0]        engRxData,
  input  logic              engNack,
  input  logic              engArbLost,
  input  logic              engBusy,
  output logic              ctrlEnable,
  output logic              ctrlFast,
  output logic [TIME_W-1:0] sclLowCnt,
  output logic [TIME_W-1:0] sclHighCnt,
  output logic [TIME_W-1:0] sdaHoldCnt,
  output logic              irq
);

  strobe_t          strobes;
  ctrl_t            ctrlReg;
  logic [NFLAG-1:0] stat, ien;
  logic [LVL_W-1:0] cmdLevel, rxLevel;
  logic             rxFull;

  assign ctrlEnable = ctrlReg.enable;
  assign ctrlFast   = ctrlReg.fast;

  i2c_front_ctrl #(.LVL_W(LVL_W)) ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .ctrlReg    (ctrlReg),
    .cmdLevel   (cmdLevel),
    .rxLevel    (rxLevel),
    .rxFull     (rxFull),
    .engRxPush  (engRxPush),
    .engNack    (engNack),
    .engArbLost (engArbLost),
    .strobes    (strobes),
    .stat       (stat),
    .ien        (ien),
    .irq        (irq)
  );

  i2c_front_dp #(.DEPTH(DEPTH), .TIME_W(TIME_W), .LVL_W(LVL_W)) dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .stat        (stat),
    .ien         (ien),
    .engBusy     (engBusy),
    .engCmdPop   (engCmdPop),
    .engRxPush   (engRxPush),
    .engRxData   (engRxData),
    .ctrlReg     (ctrlReg),
    .regRdData   (regRdData),
    .cmdLevel    (cmdLevel),
    .rxLevel     (rxLevel),
    .rxFull      (rxFull),
    .engCmdValid (engCmdValid),
    .engCmdData  (engCmdData),
    .sclLowCnt   (sclLowCnt),
    .sclHighCnt  (sclHighCnt),
    .sdaHoldCnt  (sdaHoldCnt)
  );

endmodule

// File: rtl/i2c_reg_front_chk.sv
module i2c_reg_front_chk
  import i2c_front_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input ctrl_t             ctrlReg,
  input logic [LVL_W-1:0]  cmdLevel,
  input logic [LVL_W-1:0]  rxLevel,
  input logic [NFLAG-1:0]  stat,
  input logic [NFLAG-1:0]  ien,
  input logic              irq,
  input logic              engCmdValid,
  input logic              engRxPush,
  input logic              engNack,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData
);

  logic statWr;
  assign statWr = regWrEn && (regAddr == A_STAT);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdLevel <= LVL_W'(DEPTH)) && (rxLevel <= LVL_W'(DEPTH)));

  assert_valid_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    engCmdValid == (cmdLevel != '0));

  assert_no_silent_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (engRxPush && ctrlReg.enable && rxLevel == LVL_W'(DEPTH)) |=> stat[F_RXOVF]);

  assert_flush_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlReg.enable |=> (cmdLevel == '0 && rxLevel == '0));

  assert_w1c_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (statWr && regWrData[F_NACK] && !engNack) |=> !stat[F_NACK]);

  assert_txrdy_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlReg.enable && cmdLevel <= LVL_W'(ctrlReg.cmdThr) &&
     !(statWr && regWrData[F_TXRDY])) |=> stat[F_TXRDY]);

endmodule

bind i2c_reg_front i2c_reg_front_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrlReg     (ctrlReg),
  .cmdLevel    (cmdLevel),
  .rxLevel     (rxLevel),
  .stat        (stat),
  .ien         (ien),
  .irq         (irq),
  .engCmdValid (engCmdValid),
  .engRxPush   (engRxPush),
  .engNack     (engNack),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData)
);

// File: tb/i2c_reg_front_test.sv
module i2c_reg_front_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        regWrEn = 0, regRdEn = 0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engCmdValid;
  logic [9:0]  engCmdData;
  logic        engCmdPop = 0, engRxPush = 0, engNack = 0, engArbLost = 0, engBusy = 0;
  logic [7:0]  engRxData = '0;
  logic        ctrlEnable, ctrlFast, irq;
  logic [15:0] sclLowCnt, sclHighCnt, sdaHoldCnt;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_reg_front uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engCmdValid(engCmdValid), .engCmdData(engCmdData), .engCmdPop(engCmdPop),
    .engRxPush(engRxPush), .engRxData(engRxData), .engNack(engNack),
    .engArbLost(engArbLost), .engBusy(engBusy), .ctrlEnable(ctrlEnable),
    .ctrlFast(ctrlFast), .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt),
    .sdaHoldCnt(sdaHoldCnt), .irq(irq)
  );

  // word indexes
  localparam logic [3:0] W_CMD = 0, W_RXD = 1, W_CTRL = 2, W_IEN = 3, W_STAT = 4,
    W_CORE = 5, W_CMDLVL = 6, W_RXLVL = 7, W_SCLLO = 8, W_SCLHI = 9, W_HOLD = 10;

  // {isRead, req, addr, data, expect}
  localparam int NV = 27;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 4'd2,  W_CTRL,   32'h01,    32'h0},    // R2 enable
    {1'b1, 4'd2,  W_CTRL,   32'h0,     32'h01},   // R2
    {1'b0, 4'd11, W_SCLLO,  32'h1234,  32'h0},    // R11
    {1'b1, 4'd11, W_SCLLO,  32'h0,     32'h1234}, // R11
    {1'b0, 4'd11, W_SCLHI,  32'hABCDE, 32'h0},    // R11 truncated to 16 bits
    {1'b1, 4'd11, W_SCLHI,  32'h0,     32'hBCDE}, // R11
    {1'b0, 4'd11, W_HOLD,   32'h1E,    32'h0},    // R11
    {1'b1, 4'd11, W_HOLD,   32'h0,     32'h1E},   // R11
    {1'b1, 4'd5,  W_STAT,   32'h0,     32'h01},   // R5 empty cmd fifo
    {1'b0, 4'd3,  W_CMD,    32'h201,   32'h0},    // R3
    {1'b0, 4'd3,  W_CMD,    32'h0AA,   32'h0},    // R3
    {1'b1, 4'd3,  W_CMDLVL, 32'h0,     32'h2},    // R3
    {1'b0, 4'd9,  W_STAT,   32'h1F,    32'h0},    // R9 clear all
    {1'b1, 4'd9,  W_STAT,   32'h0,     32'h0},    // R9
    {1'b0, 4'd3,  W_CMD,    32'h0BB,   32'h0},    // R3
    {1'b0, 4'd3,  W_CMD,    32'h1CC,   32'h0},    // R3
    {1'b0, 4'd3,  W_CMD,    32'h3DD,   32'h0},    // R3 full, dropped
    {1'b1, 4'd3,  W_CMDLVL, 32'h0,     32'h4},    // R3
    {1'b0, 4'd10, W_IEN,    32'h1F,    32'h0},    // R10
    {1'b1, 4'd10, W_IEN,    32'h0,     32'h1F},   // R10
    {1'b1, 4'd11, W_CORE,   32'h0,     32'h0},    // R11 idle engine
    {1'b1, 4'd4,  W_RXD,    32'h0,     32'h0},    // R4 empty read
    {1'b1, 4'd4,  W_RXLVL,  32'h0,     32'h0},    // R4
    {1'b1, 4'd13, 4'd15,    32'h0,     32'h0},    // R13 unmapped read
    {1'b1, 4'd13, W_CMD,    32'h0,     32'h0},    // R13 write-only word
    {1'b0, 4'd13, 4'd15,    32'hFFFF,  32'h0},    // R13 unmapped write
    {1'b1, 4'd13, W_CTRL,   32'h0,     32'h01}    // R13 nothing changed
  };

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input int req,
                    input string what);
    regAddr = a; regRdEn = 1;
    #1 check(what, req, regRdData, exp);
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic rxPush(input logic [7:0] d);
    engRxData = d; engRxPush = 1;
    @(negedge clk);
    engRxPush = 0;
  endtask

  task automatic cmdPop(input logic [9:0] exp, input int req);
    check("command head", req, 32'(engCmdData), 32'(exp));
    check("command valid", req, 32'(engCmdValid), 32'h1);
    engCmdPop = 1;
    @(negedge clk);
    engCmdPop = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired before the run completed");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("irq after reset R1", 1, 32'(irq), 0);
    check("cmd valid after reset R1", 1, 32'(engCmdValid), 0);
    rd(W_CTRL, 0, 1, "ctrl after reset");
    rd(W_STAT, 0, 1, "status after reset");
    rd(W_CMDLVL, 0, 1, "cmd level after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) rd(VEC[i][67:64], VEC[i][31:0], int'(VEC[i][71:68]), $sformatf("vector %0d", i));
      else            wr(VEC[i][67:64], VEC[i][63:32]);
    end

    // R3 order of commands to the engine, full write dropped
    cmdPop(10'h201, 3);
    cmdPop(10'h0AA, 3);
    cmdPop(10'h0BB, 3);
    cmdPop(10'h1CC, 3);
    check("cmd valid after drain R3", 3, 32'(engCmdValid), 0);
    tick();
    rd(W_STAT, 32'h01, 5, "tx ready at empty");
    check("irq with tx ready enabled R10", 10, 32'(irq), 1);
    // R9 clear wins, then the level bit returns
    wr(W_STAT, 32'h01);
    rd(W_STAT, 32'h00, 9, "cleared ready bit");
    rd(W_STAT, 32'h01, 9, "ready bit returns");

    // R5 threshold 3
    wr(W_CTRL, 32'h0D);
    for (int i = 0; i < 4; i++) wr(W_CMD, 32'h10 + i);
    wr(W_STAT, 32'h01);
    rd(W_STAT, 32'h00, 5, "level 4 above threshold 3");
    cmdPop(10'h010, 5);
    tick();
    rd(W_STAT, 32'h01, 5, "level 3 at threshold 3");
    cmdPop(10'h011, 3);
    cmdPop(10'h012, 3);
    cmdPop(10'h013, 3);

    // R6 RX threshold 1
    wr(W_CTRL, 32'h11);
    wr(W_STAT, 32'h1F);
    rxPush(8'h5A);
    tick();
    rd(W_STAT, 32'h01, 6, "rx level 1 not above 1");
    rxPush(8'hA5);
    tick();
    rd(W_STAT, 32'h03, 6, "rx level 2 above 1");
    rd(W_RXLVL, 32'h2, 4, "rx level");
    rd(W_RXD, 32'h5A, 4, "first rx byte");
    rd(W_RXD, 32'hA5, 4, "second rx byte");
    rd(W_RXD, 32'h00, 4, "empty rx read");

    // R7 overflow
    rxPush(8'h11); rxPush(8'h22); rxPush(8'h33); rxPush(8'h44);
    rxPush(8'h55);
    rd(W_STAT, 32'h13, 7, "overflow flag");
    rd(W_RXLVL, 32'h4, 7, "level after overflow");
    rd(W_RXD, 32'h11, 7, "rx drain 1");
    rd(W_RXD, 32'h22, 7, "rx drain 2");
    rd(W_RXD, 32'h33, 7, "rx drain 3");
    rd(W_RXD, 32'h44, 7, "rx drain 4, dropped byte absent");
    rd(W_RXLVL, 32'h0, 7, "rx level after drain");

    // R8 engine events
    wr(W_STAT, 32'h1F);
    engNack = 1; tick(); engNack = 0;
    tick();
    rd(W_STAT, 32'h05, 8, "nack flag");
    engArbLost = 1; tick(); engArbLost = 0;
    tick();
    rd(W_STAT, 32'h0D, 8, "arbitration flag");
    wr(W_STAT, 32'h04);
    rd(W_STAT, 32'h09, 9, "clear only nack");

    // R10 masking
    wr(W_IEN, 32'h04);
    check("irq masked R10", 10, 32'(irq), 0);
    wr(W_IEN, 32'h08);
    check("irq from arbitration R10", 10, 32'(irq), 1);

    // R11 busy and timing outputs
    engBusy = 1;
    rd(W_CORE, 32'h1, 11, "busy status");
    engBusy = 0;
    check("scl low output R11", 11, 32'(sclLowCnt), 32'h1234);
    check("scl high output R11", 11, 32'(sclHighCnt), 32'hBCDE);
    check("hold output R11", 11, 32'(sdaHoldCnt), 32'h1E);
    wr(W_CTRL, 32'h03);
    check("enable output R2", 2, 32'(ctrlEnable), 1);
    check("fast output R2", 2, 32'(ctrlFast), 1);

    // R12 disable flushes and holds empty
    wr(W_CMD, 32'h055);
    rxPush(8'h66);
    wr(W_CTRL, 32'h00);
    tick();
    rd(W_CMDLVL, 32'h0, 12, "cmd flushed");
    rd(W_RXLVL, 32'h0, 12, "rx flushed");
    check("cmd valid when disabled R12", 12, 32'(engCmdValid), 0);
    wr(W_CMD, 32'h077);
    rd(W_CMDLVL, 32'h0, 12, "cmd write while disabled");
    rxPush(8'h99);
    rd(W_RXLVL, 32'h0, 12, "rx push while disabled");
    wr(W_STAT, 32'h1F);
    tick();
    rd(W_STAT, 32'h0, 12, "no ready bits while disabled");

    // R1 reset in the middle of activity
    wr(W_IEN, 32'h1F);
    wr(W_CTRL, 32'h01);
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    check("irq after second reset R1", 1, 32'(irq), 0);
    check("scl low after reset R1", 1, 32'(sclLowCnt), 0);
    rd(W_CTRL, 32'h0, 1, "ctrl after second reset");
    rd(W_IEN, 32'h0, 1, "ien after second reset");
    rd(W_STAT, 32'h0, 1, "status after second reset");

    done = 1;
    summary();
    $finish;
  end

endmodule